// File: doc/BRIEF.md
# T=0 Character Error Recovery Controller

This block runs the character-level error recovery of a half-duplex smart-card contact line in protocol T=0. It serializes each outgoing character onto an open-drain line, checks whether the card signals a rejection shortly after the parity bit, and retransmits the same character on its own until a programmable limit is used up. It also receives characters from the card, checks their parity, pulls the line low during the guard time when the parity is wrong so the card repeats the character, and passes good characters on.

Every timing decision advances only on `sub_tick`, a one-cycle strobe that arrives `TICKS_PER_ETU` times per elementary time unit (ETU). A frame is a low start bit, 8 data bits sent least significant bit first, and an even parity bit over the data bits. This makes a frame 10 ETU long. Both directions share one error counter and one threshold field. Reaching the threshold raises a sticky error flag, which firmware clears with a one-cycle pulse. While the flag is set, no new transmission is accepted.

Top module: `t0_retry_ctrl`

## Requirements
- R1: After reset the error flag is 0, the line is not driven, `tx_busy` is 0 and no done, fail or valid pulse is present.
- R2: An accepted character is driven as follows, each bit for one ETU: a low start bit, then data bits 0 to 7 where a 0 drives the line low, then an even-parity bit (XOR of the data bits). The line is released from 10 ETU after the start.
- R3: If the line is high when sampled at 11 ETU after the start, the character is accepted. The block pulses `tx_done` once, clears the error counter and returns to idle.
- R4: If the line is low at that 11 ETU sample, the same character is sent again. The new start bit begins exactly 15 ETU after the previous start bit.
- R5: Let the threshold field `err_limit` hold the value N. When a character has been rejected N+1 times in a row, the block pulses `tx_fail`, sends nothing more and sets `pe_flag`. A character accepted after exactly N rejections still completes with `tx_done`.
- R6: While idle, a low line at a tick begins reception. Each bit is sampled at the centre of its ETU. A character with correct even parity gives one `rx_valid` pulse with the data on `rx_data`, and the line is not driven.
- R7: A received character with wrong parity produces no `rx_valid`. The line is driven low from 10.5 ETU to 12 ETU after the start bit.
- R8: With `err_limit` = N, the flag is set on the (N+1)-th consecutive bad received character. A good character in between clears the count, so a value of 0 flags the first error and a value of 7 flags the eighth.
- R9: `pe_flag` stays set until a `pe_clr` pulse. While it is set, `tx_start` is ignored and the line stays released.
- R10: Receive errors and transmit rejections add to the same counter. When a threshold is reached, the counter returns to 0.
- R11: A `tx_start` that arrives while a character is in progress is ignored and does not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_tick | input | 1 | One-cycle strobe, TICKS_PER_ETU per ETU |
| err_limit | input | PEC_W | Allowed error count minus one |
| pe_clr | input | 1 | One-cycle pulse that clears the sticky error flag |
| tx_start | input | 1 | Request to send tx_data |
| tx_data | input | DATA_W | Character to send |
| tx_busy | output | 1 | A transmission or its retries are in progress |
| tx_done | output | 1 | One-cycle pulse: character accepted by the card |
| tx_fail | output | 1 | One-cycle pulse: retries exhausted, transmission stopped |
| rx_valid | output | 1 | One-cycle pulse: good character received |
| rx_data | output | DATA_W | Last received data bits |
| io_in | input | 1 | Sensed level of the shared contact line |
| io_drive_low | output | 1 | Pull the contact line low when 1 |
| pe_flag | output | 1 | Sticky parity-error flag |

## Verification
If the error counter holds a wrong value, the first port to show it is the number of start bits seen before `tx_fail`, or the character on which `pe_flag` rises. That shows up within one rejection cycle, which is 15 ETU. A wrong phase count moves the retry start bit, the 11 ETU rejection sample or the 10.5 ETU receive error window by whole ticks, so the bench checks each edge at the exact tick. A corrupted frame register shows up as a wrong bit on the line at the centre of the affected bit, during the very character it corrupts.

// File: rtl/t0_pkg.sv
package t0_pkg;

   // start bit plus parity bit around the data bits
   localparam int T0_FRAME_EXTRA = 2;

   typedef enum logic {
      TX_IDLE,
      TX_SEND
   } tx_state_e;

   typedef enum logic {
      RX_IDLE,
      RX_RUN
   } rx_state_e;

endpackage

// File: rtl/t0_err_count.sv
module t0_err_count #(
   parameter int PEC_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             err_evt,
   input  logic             ok_evt,
   input  logic [PEC_W-1:0] limit,
   input  logic             pe_clr,
   output logic             hit,
   output logic             pe_flag
);

   logic [PEC_W-1:0] cnt;

   // the next error is the one that uses up the allowance
   assign hit = (cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         pe_flag <= 1'b0;
      end else begin
         if (err_evt) begin
            if (hit) begin
               cnt     <= '0;
               pe_flag <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else if (ok_evt) begin
            cnt <= '0;
         end
         if (pe_clr && !(err_evt && hit)) begin
            pe_flag <= 1'b0;
         end
      end
   end

   // R8
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pe_flag) |-> $past(err_evt));

   // R9
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_flag && !pe_clr) |=> pe_flag);

endmodule

// File: rtl/t0_tx_ctrl.sv
module t0_tx_ctrl
   import t0_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int T         = 2,
   parameter int RETRY_ETU = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              tx_start,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              pe_flag,
   input  logic              rx_busy,
   input  logic              io_in,
   input  logic              err_hit,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic              drive_low,
   output logic              err_evt,
   output logic              ok_evt
);

   localparam int FB      = DATA_W + T0_FRAME_EXTRA;
   localparam int SAMP_T  = (FB + 1) * T;
   localparam int RETRY_T = RETRY_ETU * T;
   localparam int PH_W    = $clog2(RETRY_T + 1);
   localparam int LG      = $clog2(T);

   tx_state_e         st;
   logic [PH_W-1:0]   ph;
   logic [PH_W-1:0]   nxt;
   logic [FB-1:0]     sh;
   logic [FB-1:0]     orig;
   logic              at_samp;
   logic              at_retry;

   assign nxt      = ph + 1'b1;
   assign busy     = (st == TX_SEND);
   assign at_samp  = busy && tick && (nxt == PH_W'(SAMP_T));
   assign at_retry = busy && tick && (nxt == PH_W'(RETRY_T));
   assign err_evt  = at_samp && !io_in;
   assign ok_evt   = at_samp && io_in;
   // shifted-in ones release the line once the frame is out
   assign drive_low = busy && !sh[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= TX_IDLE;
         ph   <= '0;
         sh   <= '1;
         orig <= '1;
         done <= 1'b0;
         fail <= 1'b0;
      end else begin
         done <= 1'b0;
         fail <= 1'b0;
         case (st)
            TX_IDLE: begin
               if (tx_start && !pe_flag && !rx_busy) begin
                  orig <= {^tx_data, tx_data, 1'b0};
                  sh   <= {^tx_data, tx_data, 1'b0};
                  ph   <= '0;
                  st   <= TX_SEND;
               end
            end
            TX_SEND: begin
               if (tick) begin
                  ph <= nxt;
                  if (nxt[LG-1:0] == '0) begin
                     sh <= {1'b1, sh[FB-1:1]};
                  end
                  if (at_samp) begin
                     if (io_in) begin
                        done <= 1'b1;
                        st   <= TX_IDLE;
                     end else if (err_hit) begin
                        fail <= 1'b1;
                        st   <= TX_IDLE;
                     end
                  end
                  if (at_retry) begin
                     ph <= '0;
                     sh <= orig;
                  end
               end
            end
            default: st <= TX_IDLE;
         endcase
      end
   end

   // R9
   start_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && tx_start && pe_flag) |=> !busy);

   // R5
   fail_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> pe_flag);

   // R3
   done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));

endmodule

// File: rtl/t0_rx_ctrl.sv
module t0_rx_ctrl
   import t0_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int T      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              enable,
   input  logic              io_in,
   output logic              busy,
   output logic              valid,
   output logic [DATA_W-1:0] data,
   output logic              nack,
   output logic              err_evt,
   output logic              ok_evt
);

   localparam int FB      = DATA_W + T0_FRAME_EXTRA;
   localparam int FRAME_T = FB * T;
   localparam int NACK_ON = FRAME_T + T / 2;
   localparam int NACK_OFF = FRAME_T + 2 * T;
   localparam int PH_W    = $clog2(NACK_OFF + 1);
   localparam int LG      = $clog2(T);

   rx_state_e        st;
   logic [PH_W-1:0]  ph;
   logic [PH_W-1:0]  nxt;
   logic [PH_W-1:0]  bit_k;
   logic             par_bit;
   logic             bad;
   logic             at_dec;
   logic             mid;

   assign busy    = (st == RX_RUN);
   assign nxt     = ph + 1'b1;
   assign bit_k   = nxt >> LG;
   assign mid     = (nxt[LG-1:0] == LG'(T / 2));
   assign bad     = (^data) ^ par_bit;
   assign at_dec  = busy && tick && (nxt == PH_W'(NACK_ON));
   assign err_evt = at_dec && bad;
   assign ok_evt  = at_dec && !bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= RX_IDLE;
         ph      <= '0;
         data    <= '0;
         par_bit <= 1'b0;
         nack    <= 1'b0;
         valid   <= 1'b0;
      end else begin
         valid <= 1'b0;
         case (st)
            RX_IDLE: begin
               if (tick && enable && !io_in) begin
                  st <= RX_RUN;
                  ph <= '0;
               end
            end
            RX_RUN: begin
               if (tick) begin
                  ph <= nxt;
                  if (mid) begin
                     if (bit_k == '0) begin
                        if (io_in) st <= RX_IDLE;
                     end else if (bit_k <= PH_W'(DATA_W)) begin
                        data <= {io_in, data[DATA_W-1:1]};
                     end else if (bit_k == PH_W'(DATA_W + 1)) begin
                        par_bit <= io_in;
                     end
                  end
                  if (at_dec) begin
                     if (bad) nack <= 1'b1;
                     else     valid <= 1'b1;
                  end
                  if (nxt == PH_W'(NACK_OFF)) begin
                     nack <= 1'b0;
                     st   <= RX_IDLE;
                  end
               end
            end
            default: st <= RX_IDLE;
         endcase
      end
   end

   // R7
   nack_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nack) |-> $past(tick));

   // R6
   valid_no_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> !nack);

endmodule

// File: rtl/t0_retry_ctrl.sv
module t0_retry_ctrl #(
   parameter int DATA_W        = 8,
   parameter int PEC_W         = 3,
   parameter int TICKS_PER_ETU = 2,
   parameter int RETRY_ETU     = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sub_tick,
   input  logic [PEC_W-1:0]  err_limit,
   input  logic              pe_clr,
   input  logic              tx_start,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_busy,
   output logic              tx_done,
   output logic              tx_fail,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   input  logic              io_in,
   output logic              io_drive_low,
   output logic              pe_flag
);

   generate
      if (TICKS_PER_ETU < 2 || (TICKS_PER_ETU & (TICKS_PER_ETU - 1)) != 0) begin : g_bad_ticks
         $error("TICKS_PER_ETU must be a power of two of at least 2");
      end
      if (RETRY_ETU < DATA_W + 4) begin : g_bad_retry
         $error("RETRY_ETU must leave room for the rejection window");
      end
      if (PEC_W < 1) begin : g_bad_pec
         $error("PEC_W must be at least 1");
      end
   endgenerate

   logic tx_err, tx_ok, rx_err, rx_ok;
   logic rx_busy, rx_nack, tx_drive, hit;

   t0_err_count #(.PEC_W(PEC_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .err_evt (tx_err | rx_err),
      .ok_evt  (tx_ok | rx_ok),
      .limit   (err_limit),
      .pe_clr  (pe_clr),
      .hit     (hit),
      .pe_flag (pe_flag)
   );

   t0_tx_ctrl #(.DATA_W(DATA_W), .T(TICKS_PER_ETU), .RETRY_ETU(RETRY_ETU)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (sub_tick),
      .tx_start  (tx_start),
      .tx_data   (tx_data),
      .pe_flag   (pe_flag),
      .rx_busy   (rx_busy),
      .io_in     (io_in),
      .err_hit   (hit),
      .busy      (tx_busy),
      .done      (tx_done),
      .fail      (tx_fail),
      .drive_low (tx_drive),
      .err_evt   (tx_err),
      .ok_evt    (tx_ok)
   );

   t0_rx_ctrl #(.DATA_W(DATA_W), .T(TICKS_PER_ETU)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (sub_tick),
      .enable  (!tx_busy),
      .io_in   (io_in),
      .busy    (rx_busy),
      .valid   (rx_valid),
      .data    (rx_data),
      .nack    (rx_nack),
      .err_evt (rx_err),
      .ok_evt  (rx_ok)
   );

   assign io_drive_low = tx_drive | rx_nack;

   // R10
   one_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_busy && rx_busy));

endmodule

// File: tb/tb_t0_retry_ctrl.sv
module tb_t0_retry_ctrl;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tick;
   logic [2:0] limit;
   logic       pe_clr;
   logic       tx_start;
   logic [7:0] tx_data;
   logic       tx_busy, tx_done, tx_fail, rx_valid, io_drive_low, pe_flag;
   logic [7:0] rx_data;
   logic       card_low;
   logic       io_line;

   int errors = 0;
   int checks = 0;
   int n_done = 0, n_fail = 0, n_valid = 0;

   always #10 clk = ~clk;

   assign io_line = ~(io_drive_low | card_low);

   t0_retry_ctrl dut (
      .clk(clk), .rst_n(rst_n), .sub_tick(tick), .err_limit(limit), .pe_clr(pe_clr),
      .tx_start(tx_start), .tx_data(tx_data), .tx_busy(tx_busy), .tx_done(tx_done),
      .tx_fail(tx_fail), .rx_valid(rx_valid), .rx_data(rx_data), .io_in(io_line),
      .io_drive_low(io_drive_low), .pe_flag(pe_flag)
   );

   always @(negedge clk) begin
      if (tx_done)  n_done++;
      if (tx_fail)  n_fail++;
      if (rx_valid) n_valid++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_tick();
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic start_tx(input logic [7:0] v);
      @(negedge clk) begin tx_start = 1'b1; tx_data = v; end
      @(negedge clk) tx_start = 1'b0;
   endtask

   task automatic clear_flag();
      @(negedge clk) pe_clr = 1'b1;
      @(negedge clk) pe_clr = 1'b0;
   endtask

   // card rejects the first `nacks` attempts; counts starts and misplaced restarts
   task automatic run_tx(input logic [7:0] d, input int nacks, output int starts, output int gap_bad);
      int  k;
      logic prev_low;
      start_tx(d);
      starts = 1; gap_bad = 0; k = 0; prev_low = 1'b1;
      for (int t = 0; t < 400 && tx_busy; t++) begin
         k++;
         card_low = (starts <= nacks) && (k >= 22) && (k <= 24);
         do_tick();
         if (io_drive_low && !prev_low && k >= 25) begin
            if (k != 30) gap_bad++;
            starts++;
            k = 0;
         end
         prev_low = io_drive_low;
      end
      card_low = 1'b0;
   endtask

   // card sends one character; records our drive inside the guard time
   task automatic rx_char(input logic [7:0] d, input bit bad_par,
                          output bit early, output bit lo21, output bit lo23, output bit lo24);
      logic [9:0] fr;
      fr = {(^d) ^ bad_par, d, 1'b0};
      early = 1'b0; lo21 = 1'b0; lo23 = 1'b0; lo24 = 1'b0;
      card_low = 1'b1;
      do_tick();
      for (int n = 1; n <= 24; n++) begin
         card_low = (n <= 20) ? ~fr[(n - 1) >> 1] : 1'b0;
         do_tick();
         if (n <= 20 && io_drive_low) early = 1'b1;
         if (n == 21) lo21 = io_drive_low;
         if (n == 23) lo23 = io_drive_low;
         if (n == 24) lo24 = io_drive_low;
      end
      card_low = 1'b0;
      do_tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int st, gb, v0, d0, f0;
      bit e, a, b, c;
      logic [9:0] cap;
      rst_n = 1'b0; tick = 1'b0; limit = '0; pe_clr = 1'b0;
      tx_start = 1'b0; tx_data = '0; card_low = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(pe_flag == 1'b0, "R1 flag", pe_flag, 0);
      chk(io_drive_low == 1'b0, "R1 line", io_drive_low, 0);
      chk(tx_busy == 1'b0, "R1 busy", tx_busy, 0);
      chk(!tx_done && !tx_fail && !rx_valid, "R1 pulses", tx_done + tx_fail + rx_valid, 0);

      // R2/R3/R11 framing sweep, card accepts
      for (int d = 0; d < 256; d++) begin
         d0 = n_done;
         cap = '0;
         start_tx(d[7:0]);
         for (int k = 1; k <= 22; k++) begin
            if (k == 5) start_tx(~d[7:0]);
            do_tick();
            if ((k % 2) == 1 && k < 20) cap[k >> 1] = io_line;
            if (k == 20) chk(!io_drive_low, "R2 release at 10 ETU", io_drive_low, 0);
         end
         chk(cap == {^d[7:0], d[7:0], 1'b0}, "R2 R11 frame bits", int'(cap), int'({^d[7:0], d[7:0], 1'b0}));
         chk(n_done == d0 + 1, "R3 done pulse", n_done - d0, 1);
         chk(!tx_busy, "R3 idle after accept", tx_busy, 0);
      end

      // R4/R5/R9 limit sweep
      for (int L = 0; L < 8; L++) begin
         limit = L[2:0];
         f0 = n_fail; d0 = n_done;
         run_tx(8'hA5, 99, st, gb);
         chk(st == L + 1, "R5 attempts before stop", st, L + 1);
         chk(gb == 0, "R4 restart at 15 ETU", gb, 0);
         chk(n_fail == f0 + 1 && n_done == d0, "R5 fail pulse", n_fail - f0, 1);
         chk(pe_flag, "R5 flag set", pe_flag, 1);
         start_tx(8'h3C);
         do_tick(); do_tick();
         chk(!tx_busy && !io_drive_low, "R9 start ignored while flagged", tx_busy + io_drive_low, 0);
         chk(pe_flag, "R9 flag sticky", pe_flag, 1);
         clear_flag();
         chk(!pe_flag, "R9 flag cleared", pe_flag, 0);
         d0 = n_done;
         run_tx(8'h5A, L, st, gb);
         chk(st == L + 1 && n_done == d0 + 1, "R5 accept after N rejections", st, L + 1);
         chk(!pe_flag && gb == 0, "R4 R5 no flag at boundary", pe_flag, 0);
      end

      // R3 counter cleared by an accepted character
      limit = 3'd3;
      run_tx(8'h11, 2, st, gb);
      d0 = n_done;
      run_tx(8'h22, 3, st, gb);
      chk(st == 4 && n_done == d0 + 1 && !pe_flag, "R3 counter cleared", st, 4);

      // R6 receive sweep with good parity
      limit = 3'd7;
      for (int d = 0; d < 256; d++) begin
         v0 = n_valid;
         rx_char(d[7:0], 1'b0, e, a, b, c);
         chk(n_valid == v0 + 1 && rx_data == d[7:0], "R6 data", int'(rx_data), d);
         chk(!e && !a && !b && !c, "R6 no drive", int'({e, a, b, c}), 0);
      end

      // R7 bad parity window
      for (int d = 0; d < 6; d++) begin
         v0 = n_valid;
         rx_char(8'h35 + d[7:0], 1'b1, e, a, b, c);
         chk(!e && a && b && !c, "R7 error window", int'({e, a, b, c}), 6);
         chk(n_valid == v0, "R7 no valid", n_valid - v0, 0);
      end
      clear_flag();
      rx_char(8'h00, 1'b0, e, a, b, c);

      // R8 consecutive receive errors
      for (int L = 0; L < 8; L++) begin
         limit = L[2:0];
         for (int j = 0; j < L; j++) rx_char(8'h81, 1'b1, e, a, b, c);
         chk(!pe_flag, "R8 below limit", pe_flag, 0);
         rx_char(8'h42, 1'b0, e, a, b, c);
         for (int j = 0; j < L; j++) rx_char(8'h81, 1'b1, e, a, b, c);
         chk(!pe_flag, "R8 good char clears count", pe_flag, 0);
         rx_char(8'h81, 1'b1, e, a, b, c);
         chk(pe_flag, "R8 flag at limit", pe_flag, 1);
         clear_flag();
      end

      // R10 shared counter
      limit = 3'd1;
      rx_char(8'h7E, 1'b0, e, a, b, c);
      rx_char(8'h7E, 1'b1, e, a, b, c);
      chk(!pe_flag, "R10 one rx error", pe_flag, 0);
      f0 = n_fail;
      run_tx(8'h99, 99, st, gb);
      chk(st == 1 && n_fail == f0 + 1 && pe_flag, "R10 shared count", st, 1);
      clear_flag();
      d0 = n_done;
      run_tx(8'h66, 1, st, gb);
      chk(st == 2 && n_done == d0 + 1 && !pe_flag, "R10 count reset after limit", st, 2);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule